// File: doc/BRIEF.md
# Serial Flash Word Reader

This block lets a processor fetch instructions or constants straight out of a four-wire serial flash. A read of the flash window on its pipelined slave bus becomes one serial transaction. Chip select drops, the 8-bit read opcode goes out, then the 24-bit byte address, and then 32 data bits come back. Bits move most significant first in SPI mode 0. The returned word has the first byte received in bits [31:24]. A word address `a` is sent as the byte address `{a, 2'b00}`, zero-extended to 24 bits. The `spi_sck` output is a clock enable: each cycle where it is high stands for one full SCK pulse, made by a double-data-rate output cell at chip level.

With `OPT_PIPE` set, a read of the next word can be accepted during the last SCK cycle of the current word. Chip select then stays low and the extra word costs only 32 more SCK cycles. A separate control register selects the override path. Through it, software sets the override chip-select level and swaps one byte with the flash, which is how erase and program sequences are done.

Top module: `spi_rd_ctrl`

## Requirements
- R1: During and after reset, `spi_cs_n` is 1, `spi_sck` is 0, `bus_ack` is 0 and `bus_stall` is 0.
- R2: A read accepted while idle with `bus_adr[ADDR_W]`=0 gives exactly 64 consecutive SCK cycles with chip select low. `spi_mosi` carries 8'h03 and then the byte address `{bus_adr[ADDR_W-1:0],2'b00}`, MSB first, one bit per SCK cycle.
- R3: `spi_miso` is sampled at the end of SCK cycles 33 to 64, and the first bit lands in bit 31. `bus_ack` is high for one cycle, 65 cycles after the accepting edge, with the word on `bus_rdat`. Without a pipelined follow-on, `spi_cs_n` is already high in that cycle.
- R4: `spi_sck` is never high while `spi_cs_n` is high.
- R5: With `OPT_PIPE`=1, a flash read of word address previous+1 that is waiting during the 64th (or later last) SCK cycle is accepted in that cycle. It receives its word after 32 more SCK cycles, with chip select held low and no new opcode or address.
- R6: While a transfer runs, any other request is stalled until the ack cycle: a write, a control access, or a non-sequential read. A held read then starts a fresh 64-cycle transaction.
- R7: With `OPT_PIPE`=0, a sequential read is stalled like any other until the transfer ends.
- R8: A write to the control register (`bus_adr[ADDR_W]`=1) with `bus_wdat[8]`=0 drives chip select low. It sends `bus_wdat[7:0]` MSB first in 8 SCK cycles, records the 8 bits received, and acks 9 cycles after acceptance.
- R9: A control write with `bus_wdat[8]`=1 raises chip select, makes no SCK cycle, and acks in the next cycle.
- R10: A control read acks in the next cycle with no SCK activity. It returns {22'b0, busy in bit 9, override chip-select level in bit 8, last received byte in bits [7:0]}.
- R11: A write to the flash window acks in the next cycle and causes no SCK activity.
- R12: Each accepted request gets exactly one single-cycle ack. If `bus_cyc` falls during a transfer, SCK stops on the next edge and the read's chip select is released. That request then gets no ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | Write request |
| bus_adr | input | ADDR_W+1 | Word address; top bit selects the control register |
| bus_wdat | input | 32 | Write data (bits [8:0] used by the control register) |
| bus_stall | output | 1 | Request cannot be taken this cycle |
| bus_ack | output | 1 | Single-cycle response |
| bus_rdat | output | 32 | Read data, valid with `bus_ack` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SCK pulse enable for the chip-level DDR output |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Reads go to a low address, to address zero and to the top of the word space. Each is checked against a behavioural flash that decodes the opcode and address it receives, which separates address-bit placement errors from data-ordering errors. A sequential follow-on read is held against the block during the final bit. It is compared with a second, non-pipelined instance on the same bus, so early acceptance and its absence are both observed. A non-sequential read and a sequential-address write are also held during a transfer, which shows that early release depends on the address and the direction. Control writes with chip select low and high, control reads, flash-window writes and a dropped bus cycle cover the override path and the ack accounting.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_BYTE = 2'd2
   } spi_rd_state_e;

   localparam logic [7:0] CMD_READ = 8'h03;
   localparam int WORD_W    = 32;
   localparam int FLASH_AW  = 24;
   localparam int CMD_BITS  = 8;
   localparam int BYTE_BITS = 8;
endpackage

// File: rtl/spi_rd_shreg.sv
module spi_rd_shreg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         capture,
   input  logic         miso,
   output logic         mosi,
   output logic [W-1:0] rx_nxt
);
   logic [W-1:0] tx_q;
   logic [W-1:0] rx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)
            tx_q <= load_val;
         else if (step)
            tx_q <= {tx_q[W-2:0], 1'b0};
         if (capture)
            rx_q <= rx_nxt;
      end
   end

   assign mosi   = tx_q[W-1];
   assign rx_nxt = {rx_q[W-2:0], miso};
endmodule

// File: rtl/spi_rd_seqaddr.sv
module spi_rd_seqaddr #(
   parameter int AW = 22
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          take,
   input  logic [AW-1:0] take_adr,
   output logic [AW-1:0] next_adr
);
   always_ff @(posedge clk) begin
      if (rst)
         next_adr <= '0;
      else if (take)
         next_adr <= take_adr + 1'b1;
   end
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
   import spi_rd_pkg::*;
#(
   parameter int ADDR_W   = 22,
   parameter bit OPT_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cyc,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [ADDR_W:0]   bus_adr,
   input  logic [31:0]       bus_wdat,
   output logic              bus_stall,
   output logic              bus_ack,
   output logic [31:0]       bus_rdat,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int CNT_W = 7;
   localparam int READ_BITS = CMD_BITS + FLASH_AW + WORD_W;
   localparam logic [CNT_W-1:0] LAST_READ  = CNT_W'(READ_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_BYTE  = CNT_W'(BYTE_BITS - 1);
   localparam logic [CNT_W-1:0] DATA_START = CNT_W'(CMD_BITS + FLASH_AW);

   if (ADDR_W < 1 || ADDR_W > FLASH_AW - 2) begin : g_bad_addr_w
      $error("ADDR_W must lie between 1 and 22");
   end
   if (READ_BITS >= (1 << CNT_W)) begin : g_bad_cnt_w
      $error("bit counter too narrow");
   end

   spi_rd_state_e    state;
   logic [CNT_W-1:0] cnt;
   logic             sck_r;
   logic             rd_cs_n;
   logic             ovr_cs_n;
   logic [7:0]       ovr_rx;
   logic             ack_r;
   logic [31:0]      rdat_r;

   logic             is_ctl;
   logic             accept;
   logic             pipe_take;
   logic             start_any;
   logic [WORD_W-1:0] load_val;
   logic [WORD_W-1:0] rx_nxt;
   logic [FLASH_AW-1:0] byte_adr;
   logic [31:0]      status_word;
   logic             capture;
   logic             unused_wdat;

   assign unused_wdat = ^bus_wdat[31:9];

   assign is_ctl    = bus_adr[ADDR_W];
   assign bus_stall = (state != ST_IDLE) && !pipe_take;
   assign accept    = bus_cyc && bus_stb && !bus_stall;
   assign byte_adr  = FLASH_AW'({bus_adr[ADDR_W-1:0], 2'b00});
   assign status_word = 32'({(state != ST_IDLE), ovr_cs_n, ovr_rx});

   assign start_any = accept && (state == ST_IDLE) &&
                      ((!is_ctl && !bus_we) || (is_ctl && bus_we && !bus_wdat[8]));
   assign load_val  = is_ctl ? {bus_wdat[7:0], {(WORD_W-BYTE_BITS){1'b0}}}
                             : {CMD_READ, byte_adr};
   assign capture   = sck_r && ((state == ST_BYTE) || (cnt >= DATA_START));

   spi_rd_shreg #(.W(WORD_W)) u_shreg (
      .clk      (clk),
      .rst      (rst),
      .load     (start_any),
      .load_val (load_val),
      .step     (sck_r),
      .capture  (capture),
      .miso     (spi_miso),
      .mosi     (spi_mosi),
      .rx_nxt   (rx_nxt)
   );

   if (OPT_PIPE) begin : g_pipe
      logic [ADDR_W-1:0] next_adr;

      spi_rd_seqaddr #(.AW(ADDR_W)) u_seq (
         .clk      (clk),
         .rst      (rst),
         .take     (accept && !is_ctl && !bus_we),
         .take_adr (bus_adr[ADDR_W-1:0]),
         .next_adr (next_adr)
      );

      assign pipe_take = (state == ST_READ) && (cnt == LAST_READ) &&
                         bus_cyc && bus_stb && !bus_we && !is_ctl &&
                         (bus_adr[ADDR_W-1:0] == next_adr);
   end else begin : g_nopipe
      assign pipe_take = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sck_r    <= 1'b0;
         rd_cs_n  <= 1'b1;
         ovr_cs_n <= 1'b1;
         ovr_rx   <= '0;
         ack_r    <= 1'b0;
         rdat_r   <= '0;
      end else begin
         ack_r <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (is_ctl && bus_we) begin
                     ovr_cs_n <= bus_wdat[8];
                     if (bus_wdat[8]) begin
                        ack_r <= 1'b1;
                     end else begin
                        state <= ST_BYTE;
                        sck_r <= 1'b1;
                        cnt   <= '0;
                     end
                  end else if (is_ctl) begin
                     ack_r  <= 1'b1;
                     rdat_r <= status_word;
                  end else if (bus_we) begin
                     ack_r <= 1'b1;
                  end else begin
                     state   <= ST_READ;
                     rd_cs_n <= 1'b0;
                     sck_r   <= 1'b1;
                     cnt     <= '0;
                  end
               end
            end
            ST_READ: begin
               if (!bus_cyc) begin
                  state   <= ST_IDLE;
                  sck_r   <= 1'b0;
                  rd_cs_n <= 1'b1;
               end else if (cnt == LAST_READ) begin
                  ack_r  <= 1'b1;
                  rdat_r <= rx_nxt;
                  if (pipe_take) begin
                     cnt <= DATA_START;
                  end else begin
                     state   <= ST_IDLE;
                     sck_r   <= 1'b0;
                     rd_cs_n <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_BYTE: begin
               if (!bus_cyc) begin
                  state <= ST_IDLE;
                  sck_r <= 1'b0;
               end else if (cnt == LAST_BYTE) begin
                  ack_r  <= 1'b1;
                  ovr_rx <= rx_nxt[7:0];
                  state  <= ST_IDLE;
                  sck_r  <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_n = rd_cs_n & ovr_cs_n;
   assign spi_sck  = sck_r;
   assign bus_ack  = ack_r & bus_cyc;
   assign bus_rdat = rdat_r;
endmodule

// File: rtl/spi_rd_ctrl_chk.sv
module spi_rd_ctrl_chk #(
   parameter int ADDR_W = 22
) (
   input logic            clk,
   input logic            rst,
   input logic            bus_cyc,
   input logic            bus_stb,
   input logic            bus_we,
   input logic [ADDR_W:0] bus_adr,
   input logic            bus_stall,
   input logic            bus_ack,
   input logic            spi_cs_n,
   input logic            spi_sck
);
   logic [1:0]        owed;
   logic [ADDR_W-1:0] exp_next;
   logic              took;
   logic              took_rd;

   assign took    = bus_cyc && bus_stb && !bus_stall;
   assign took_rd = took && !bus_we && !bus_adr[ADDR_W];

   always_ff @(posedge clk) begin
      if (rst || !bus_cyc)
         owed <= 2'd0;
      else
         owed <= owed + {1'b0, took} - {1'b0, bus_ack};
   end

   always_ff @(posedge clk) begin
      if (rst)
         exp_next <= '0;
      else if (took_rd)
         exp_next <= bus_adr[ADDR_W-1:0] + 1'b1;
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (spi_cs_n && !spi_sck && !bus_ack));

   p_sck_needs_cs_r4: assert property (@(posedge clk) disable iff (rst)
      spi_sck |-> !spi_cs_n);

   p_early_only_next_r5: assert property (@(posedge clk) disable iff (rst)
      (spi_sck && took) |->
         (!bus_we && !bus_adr[ADDR_W] && bus_adr[ADDR_W-1:0] == exp_next));

   p_ctl_read_quick_r10: assert property (@(posedge clk) disable iff (rst)
      (took && !bus_we && bus_adr[ADDR_W]) |=> ((bus_ack || !bus_cyc) && !spi_sck));

   p_ack_is_owed_r12: assert property (@(posedge clk) disable iff (rst)
      bus_ack |-> (owed != 2'd0));

   p_drop_stops_sck_r12: assert property (@(posedge clk) disable iff (rst)
      !bus_cyc |=> !spi_sck);
endmodule

bind spi_rd_ctrl spi_rd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_cyc   (bus_cyc),
   .bus_stb   (bus_stb),
   .bus_we    (bus_we),
   .bus_adr   (bus_adr),
   .bus_stall (bus_stall),
   .bus_ack   (bus_ack),
   .spi_cs_n  (spi_cs_n),
   .spi_sck   (spi_sck)
);

// File: tb/tb_spi_rd_ctrl.sv
module tb_spi_rd_ctrl;
   localparam logic [7:0] OVR_PAT = 8'hA5;

   logic        clk = 1'b0;
   logic        rst;
   logic        bus_cyc, bus_stb, bus_we;
   logic [22:0] bus_adr;
   logic [31:0] bus_wdat;
   logic        bus_stall, bus_ack;
   logic [31:0] bus_rdat;
   logic        spi_cs_n, spi_sck, spi_mosi;
   logic        miso = 1'b0;

   logic        np_stall, np_ack, np_cs_n, np_sck, np_mosi;
   logic [31:0] np_rdat;

   int checks = 0;
   int fails  = 0;
   int sck_total = 0;
   int sck_bad   = 0;
   int accepts   = 0;
   int acks      = 0;
   int fl_cnt    = 0;
   logic [31:0] fl_cmd = '0;

   always #4 clk = ~clk;

   spi_rd_ctrl #(.ADDR_W(22), .OPT_PIPE(1'b1)) dut (
      .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
      .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_stall(bus_stall), .bus_ack(bus_ack),
      .bus_rdat(bus_rdat), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(miso));

   spi_rd_ctrl #(.ADDR_W(22), .OPT_PIPE(1'b0)) dut_np (
      .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
      .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_stall(np_stall), .bus_ack(np_ack),
      .bus_rdat(np_rdat), .spi_cs_n(np_cs_n), .spi_sck(np_sck),
      .spi_mosi(np_mosi), .spi_miso(miso));

   function automatic logic [31:0] word_at(input logic [21:0] a);
      return ({10'h0, a} * 32'h9E3779B1) ^ 32'hC3A50F1E;
   endfunction

   // flash model and port monitors, all sampled mid-cycle
   always @(negedge clk) begin
      logic [31:0] w;
      int idx;
      if (spi_sck) sck_total++;
      if (spi_sck && spi_cs_n) sck_bad++;
      if (bus_cyc && bus_stb && !bus_stall) accepts++;
      if (bus_ack) acks++;
      if (spi_cs_n) begin
         fl_cnt = 0;
      end else if (spi_sck) begin
         if (fl_cnt < 32) begin
            miso   <= OVR_PAT[7 - (fl_cnt % 8)];
            fl_cmd <= {fl_cmd[30:0], spi_mosi};
         end else begin
            idx  = fl_cnt - 32;
            w    = word_at(fl_cmd[23:2] + 22'(idx / 32));
            miso <= w[31 - (idx % 32)];
         end
         fl_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic we, input logic [22:0] adr, input logic [31:0] wd);
      @(posedge clk); #1;
      bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = adr; bus_wdat = wd;
      for (int g = 0; g < 500; g++) begin
         @(negedge clk);
         if (!bus_stall) break;
      end
      @(posedge clk); #1;
      bus_stb = 1'b0; bus_we = 1'b0;
   endtask

   task automatic get_ack(output int waits, output logic [31:0] d);
      waits = 0;
      do begin
         @(negedge clk);
         waits++;
      end while (!bus_ack && waits < 400);
      d = bus_rdat;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1 cs_n after reset", 32'(spi_cs_n), 1);
      chk(spi_sck == 1'b0, "R1 sck after reset", 32'(spi_sck), 0);
      chk(bus_stall == 1'b0 && bus_ack == 1'b0, "R1 stall/ack after reset",
          32'({bus_stall, bus_ack}), 0);
   endtask

   task automatic t_read(input logic [21:0] a);
      int w; logic [31:0] d; int s0;
      s0 = sck_total;
      issue(1'b0, {1'b0, a}, '0);
      get_ack(w, d);
      chk(w == 65, "R3 read ack latency", 32'(w), 65);
      chk(sck_total - s0 == 64, "R2 sck cycles per read", 32'(sck_total - s0), 64);
      chk(fl_cmd == {8'h03, a, 2'b00}, "R2 opcode and address", fl_cmd, {8'h03, a, 2'b00});
      chk(d == word_at(a), "R3 read data", d, word_at(a));
      chk(spi_cs_n == 1'b1, "R3 cs released at ack", 32'(spi_cs_n), 1);
      @(negedge clk);
      chk(!bus_ack, "R12 ack lasts one cycle", 32'(bus_ack), 0);
   endtask

   task automatic t_pipe(input logic [21:0] b);
      int n; int w; logic [31:0] d; int s0; logic np_st;
      s0 = sck_total; n = 0; np_st = 1'b0;
      issue(1'b0, {1'b0, b}, '0);
      bus_stb = 1'b1; bus_adr = {1'b0, b + 22'd1};
      for (int g = 0; g < 200; g++) begin
         @(negedge clk);
         n++;
         np_st = np_stall;
         if (!bus_stall) break;
      end
      chk(n == 64, "R5 next word taken in last cycle", 32'(n), 64);
      chk(np_st == 1'b1, "R7 no early take without pipeline", 32'(np_st), 1);
      @(posedge clk); #1;
      bus_stb = 1'b0;
      get_ack(w, d);
      chk(w == 1 && d == word_at(b), "R5 first word", d, word_at(b));
      get_ack(w, d);
      chk(w == 32, "R5 follow-on latency", 32'(w), 32);
      chk(d == word_at(b + 22'd1), "R5 follow-on data", d, word_at(b + 22'd1));
      chk(sck_total - s0 == 96, "R5 total sck cycles", 32'(sck_total - s0), 96);
      chk(fl_cmd == {8'h03, b, 2'b00}, "R5 no second opcode", fl_cmd, {8'h03, b, 2'b00});
   endtask

   task automatic t_busy(input logic we, input logic [21:0] c);
      int n; int w; logic [31:0] d; int s0; logic [21:0] a2; logic ack_seen;
      logic [31:0] d1;
      a2 = we ? c + 22'd1 : c + 22'd5;
      s0 = sck_total; n = 0; ack_seen = 1'b0; d1 = '0;
      issue(1'b0, {1'b0, c}, '0);
      bus_stb = 1'b1; bus_we = we; bus_adr = {1'b0, a2}; bus_wdat = 32'h1234;
      for (int g = 0; g < 200; g++) begin
         @(negedge clk);
         n++;
         ack_seen = bus_ack; d1 = bus_rdat;
         if (!bus_stall) break;
      end
      chk(n == 65, "R6 other request held to end", 32'(n), 65);
      chk(ack_seen && d1 == word_at(c), "R6 first read completes", d1, word_at(c));
      @(posedge clk); #1;
      bus_stb = 1'b0; bus_we = 1'b0;
      get_ack(w, d);
      if (we) begin
         chk(w == 1, "R6 held write acked", 32'(w), 1);
         chk(sck_total - s0 == 64, "R6 held write no sck", 32'(sck_total - s0), 64);
      end else begin
         chk(w == 65, "R6 held read is fresh", 32'(w), 65);
         chk(d == word_at(a2), "R6 held read data", d, word_at(a2));
         chk(fl_cmd == {8'h03, a2, 2'b00}, "R6 new opcode and address", fl_cmd,
             {8'h03, a2, 2'b00});
      end
   endtask

   task automatic t_override;
      int w; logic [31:0] d; int s0;
      s0 = sck_total;
      issue(1'b1, 23'h400000, 32'h0000_009C);
      get_ack(w, d);
      chk(w == 9, "R8 byte ack latency", 32'(w), 9);
      chk(sck_total - s0 == 8, "R8 eight sck cycles", 32'(sck_total - s0), 8);
      chk(fl_cmd[7:0] == 8'h9C, "R8 byte sent", 32'(fl_cmd[7:0]), 32'h9C);
      chk(spi_cs_n == 1'b0, "R8 cs held low", 32'(spi_cs_n), 0);
      s0 = sck_total;
      issue(1'b0, 23'h400000, '0);
      get_ack(w, d);
      chk(w == 1 && d == 32'h0000_00A5, "R10 status with cs low", d, 32'hA5);
      chk(sck_total == s0, "R10 status read no sck", 32'(sck_total - s0), 0);
      issue(1'b1, 23'h400000, 32'h0000_0100);
      get_ack(w, d);
      chk(w == 1, "R9 release ack latency", 32'(w), 1);
      chk(sck_total == s0, "R9 release no sck", 32'(sck_total - s0), 0);
      chk(spi_cs_n == 1'b1, "R9 cs high", 32'(spi_cs_n), 1);
      issue(1'b0, 23'h400000, '0);
      get_ack(w, d);
      chk(d == 32'h0000_01A5, "R10 status with cs high", d, 32'h1A5);
   endtask

   task automatic t_flash_write;
      int w; logic [31:0] d; int s0;
      s0 = sck_total;
      issue(1'b1, 23'h000055, 32'hDEAD_BEEF);
      get_ack(w, d);
      chk(w == 1, "R11 flash write ack latency", 32'(w), 1);
      chk(sck_total == s0 && spi_cs_n, "R11 flash write no activity",
          32'(sck_total - s0), 0);
   endtask

   task automatic t_abort;
      int seen;
      seen = 0;
      issue(1'b0, 23'h000222, '0);
      repeat (20) @(negedge clk);
      @(posedge clk); #1;
      bus_cyc = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!spi_sck && spi_cs_n, "R12 drop stops transfer", 32'({spi_sck, spi_cs_n}), 1);
      @(posedge clk); #1;
      bus_cyc = 1'b1;
      for (int g = 0; g < 80; g++) begin
         @(negedge clk);
         if (bus_ack) seen++;
      end
      chk(seen == 0, "R12 no ack after drop", 32'(seen), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
      bus_adr = '0; bus_wdat = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      t_reset;
      t_read(22'h012345);
      t_read(22'h000000);
      t_read(22'h3FFFFF);
      t_pipe(22'h000100);
      t_busy(1'b0, 22'h001000);
      t_busy(1'b1, 22'h002000);
      t_override;
      t_flash_write;
      t_abort;
      t_read(22'h000777);
      @(negedge clk);
      chk(acks == accepts - 1, "R12 one ack per accepted request", 32'(acks),
          32'(accepts - 1));
      chk(sck_bad == 0, "R4 no sck with cs high", 32'(sck_bad), 0);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule